// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a DRAM read or write burst. A start strobe captures a starting column together with the burst settings: a length code, an ordering type (sequential or interleaved) and a single-write mode bit. It also captures a read/write indicator. From the next cycle on, the block presents one column per clock with a beat-valid flag. It raises a last-beat flag on the final beat of a fixed-length burst.

A full-page burst walks the whole row and wraps around. It runs until a stop strobe ends it or a fresh start replaces it. Any burst can be cut short by the stop strobe or overridden by a new start on any cycle. When single-write mode is on, writes last exactly one beat and reads keep the programmed length. A start carrying a setting the block does not support is refused and reported on a one-cycle flag.

Top module: `burst_colgen`

## Requirements
- R1: While and right after reset, beatValid, lastBeat and illegalFlag are low.
- R2: A legal start sampled on a clock edge makes beatValid high from that edge, with colOut equal to the captured start column on the first beat.
- R3: Length codes 000, 001, 010 and 011 select 1, 2, 4 and 8 beats. With sequential ordering (burstType=0), beat n keeps the column bits above the low k bits (k = log2 of the length) and sets the low k bits to (start low bits + n) mod length.
- R4: With interleaved ordering (burstType=1), beat n is the start column with its low k bits XORed with n.
- R5: Code 111 with sequential ordering is a full-page burst. Beat n is (start + n) mod 512, it keeps running past 512 beats, and lastBeat never rises during it.
- R6: lastBeat is high on the final beat of a fixed-length burst only. beatValid is low on the following cycle unless a new start arrives.
- R7: A start with code 100, 101 or 110, or code 111 with burstType=1, is refused. A burst already running continues unchanged, and illegalFlag is high for the one cycle after that start.
- R8: A stop strobe with no start ends the running burst, so beatValid is low from the next cycle. A stop while idle changes nothing.
- R9: A legal start during a running burst replaces it at once from its own first beat, and a start takes priority over a simultaneous stop.
- R10: With singleWrite=1 and isWrite=1, a legal start gives a single beat with lastBeat high whatever the length code. Reads, and writes with singleWrite=0, use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Begin a burst with the settings below |
| startCol | input | 9 | First column of the burst |
| blCode | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| singleWrite | input | 1 | Writes are single beats when set |
| isWrite | input | 1 | 1 for a write burst, 0 for a read |
| stopStb | input | 1 | End the running burst |
| colOut | output | 9 | Column of the current beat |
| beatValid | output | 1 | colOut holds a burst beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| illegalFlag | output | 1 | Previous cycle's start was refused |

## Verification
The bench builds the block with its default 9-bit column width, so a full page is 512 beats. A run of more than 512 beats checks the wrap from column 511 back to 0 and checks that the burst keeps going with no last-beat flag. Start columns sit mid-block and near the top of the row to exercise aligned wrapping in both orderings. Starts and stops are placed mid-burst, coincident with each other, and alongside refused codes, so that override and priority can be compared with the reference model on every cycle.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } blCode_e;

  typedef struct packed {
    logic load;   // capture start settings, restart offset
    logic step;   // advance to next beat
  } dpStrobes_t;

endpackage

// File: rtl/burst_colgen_ctrl.sv
module burst_colgen_ctrl
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [2:0]       blCode,
  input  logic             burstType,
  input  logic             singleWrite,
  input  logic             isWrite,
  input  logic             stopStb,
  output dpStrobes_t       strobes,
  output logic [COL_W-1:0] lenMask,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             illegalFlag
);

  logic             codeLegal;
  logic             reqPage;
  logic [COL_W-1:0] reqMask;
  logic             accept;
  logic             atEnd;

  logic             activeQ;
  logic             pageQ;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] beatCnt;
  logic             illQ;

  always_comb begin
    codeLegal = 1'b1;
    reqPage   = 1'b0;
    reqMask   = '0;
    case (blCode)
      BL_ONE:   reqMask = '0;
      BL_TWO:   reqMask = COL_W'(1);
      BL_FOUR:  reqMask = COL_W'(3);
      BL_EIGHT: reqMask = COL_W'(7);
      BL_PAGE: begin
        reqMask   = '1;
        reqPage   = ~burstType;
        codeLegal = ~burstType;
      end
      default:  codeLegal = 1'b0;
    endcase
    if (singleWrite && isWrite) begin
      reqMask = '0;
      reqPage = 1'b0;
    end
  end

  assign accept  = startStb & codeLegal;
  assign atEnd   = activeQ & ~pageQ & (beatCnt == maskQ);
  assign lenMask = reqMask;

  always_comb begin
    strobes.load = accept;
    strobes.step = activeQ & ~accept & ~stopStb & ~atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      pageQ   <= 1'b0;
      maskQ   <= '0;
      beatCnt <= '0;
      illQ    <= 1'b0;
    end else begin
      illQ <= startStb & ~codeLegal;
      if (accept) begin
        activeQ <= 1'b1;
        pageQ   <= reqPage;
        maskQ   <= reqMask;
        beatCnt <= '0;
      end else if (stopStb || atEnd) begin
        activeQ <= 1'b0;
      end else if (activeQ) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assign beatValid   = activeQ;
  assign lastBeat    = atEnd;
  assign illegalFlag = illQ;

endmodule

// File: rtl/burst_colgen_dp.sv
module burst_colgen_dp
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] lenMask,
  input  logic             burstType,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] offset;
  logic             interQ;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] intCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      maskQ  <= '0;
      offset <= '0;
      interQ <= 1'b0;
    end else if (strobes.load) begin
      startQ <= startCol;
      maskQ  <= lenMask;
      offset <= '0;
      interQ <= burstType;
    end else if (strobes.step) begin
      offset <= offset + 1'b1;
    end
  end

  // sequential: add inside the aligned block, upper bits held
  assign seqCol = (startQ & ~maskQ) | ((startQ + offset) & maskQ);
  // interleaved: flip low bits by beat index
  assign intCol = startQ ^ (offset & maskQ);
  assign colOut = interQ ? intCol : seqCol;

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blCode,
  input  logic             burstType,
  input  logic             singleWrite,
  input  logic             isWrite,
  input  logic             stopStb,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             illegalFlag
);

  dpStrobes_t       strobes;
  logic [COL_W-1:0] lenMask;

  burst_colgen_ctrl #(.COL_W(COL_W)) ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .blCode(blCode),
    .burstType(burstType), .singleWrite(singleWrite), .isWrite(isWrite),
    .stopStb(stopStb), .strobes(strobes), .lenMask(lenMask),
    .beatValid(beatValid), .lastBeat(lastBeat), .illegalFlag(illegalFlag)
  );

  burst_colgen_dp #(.COL_W(COL_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startCol(startCol),
    .lenMask(lenMask), .burstType(burstType), .colOut(colOut)
  );

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       blCode,
  input logic             burstType,
  input logic             singleWrite,
  input logic             isWrite,
  input logic             stopStb,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat,
  input logic             illegalFlag
);

  logic legalIn;
  assign legalIn = (blCode[2] == 1'b0) || (blCode == 3'b111 && !burstType);

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    startStb && legalIn |=> beatValid && colOut == $past(startCol));

  a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rstN)
    startStb && blCode == 3'b111 && !burstType && !(singleWrite && isWrite)
      |=> beatValid && !lastBeat);

  a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  a_r6_continue: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !lastBeat && !stopStb && !startStb |=> beatValid);

  a_r7_flag_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startStb && !legalIn |=> illegalFlag);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    stopStb && !startStb |=> !beatValid);

  a_r10_single_write: assert property (@(posedge clk) disable iff (!rstN)
    startStb && legalIn && singleWrite && isWrite |=> lastBeat);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
  .blCode(blCode), .burstType(burstType), .singleWrite(singleWrite),
  .isWrite(isWrite), .stopStb(stopStb), .colOut(colOut),
  .beatValid(beatValid), .lastBeat(lastBeat), .illegalFlag(illegalFlag)
);

// File: tb/burst_colgen_test.sv
module burst_colgen_test;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       blCode = '0;
  logic             burstType = 1'b0;
  logic             singleWrite = 1'b0;
  logic             isWrite = 1'b0;
  logic             stopStb = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid;
  logic             lastBeat;
  logic             illegalFlag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit refActive = 0;
  bit refFull = 0;
  bit refInter = 0;
  bit refIll = 0;
  int refN = 0;
  int refLen = 1;
  int refStart = 0;

  always #2 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .blCode(blCode), .burstType(burstType), .singleWrite(singleWrite),
    .isWrite(isWrite), .stopStb(stopStb), .colOut(colOut),
    .beatValid(beatValid), .lastBeat(lastBeat), .illegalFlag(illegalFlag)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expCol();
    int base;
    if (refInter) return refStart ^ refN;
    base = refStart - (refStart % refLen);
    return base + ((refStart % refLen + refN) % refLen);
  endfunction

  task automatic modelEdge(bit s, int col, int code, bit typ, bit sw, bit wr, bit stp);
    bit legal;
    legal = (code < 4) || (code == 7 && !typ);
    refIll = s && !legal;
    if (s && legal) begin
      refActive = 1;
      refN = 0;
      refStart = col;
      refInter = typ;
      if (sw && wr) begin
        refLen = 1; refFull = 0;
      end else if (code == 7) begin
        refLen = PAGE; refFull = 1;
      end else begin
        refLen = 1 << code; refFull = 0;
      end
    end else if (stp) begin
      refActive = 0;
    end else if (refActive) begin
      if (!refFull && refN == refLen - 1) refActive = 0;
      else refN = (refN + 1) % PAGE;
    end
  endtask

  task automatic compareAll(string tag);
    bit expLast;
    expLast = refActive && !refFull && (refN == refLen - 1);
    check(tag, "beatValid", int'(beatValid), int'(refActive));
    check(tag, "lastBeat", int'(lastBeat), int'(expLast));
    check(tag, "illegalFlag", int'(illegalFlag), int'(refIll));
    if (refActive) check(tag, "colOut", int'(colOut), expCol());
  endtask

  task automatic step(string tag, bit s, int col, int code, bit typ, bit sw, bit wr, bit stp);
    startStb = s; startCol = COL_W'(col); blCode = 3'(code);
    burstType = typ; singleWrite = sw; isWrite = wr; stopStb = stp;
    @(posedge clk);
    modelEdge(s, col, code, typ, sw, wr, stp);
    #1;
    compareAll(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "beatValid", int'(beatValid), 0);
    check("R1", "lastBeat", int'(lastBeat), 0);
    check("R1", "illegalFlag", int'(illegalFlag), 0);
    rstN = 1'b1;
    idle("R1", 2);

    // R2/R3 sequential fixed lengths
    step("R2", 1, 'h00D, 2, 0, 0, 0, 0);
    idle("R3", 5);
    step("R3", 1, 'h1FE, 3, 0, 0, 0, 0);
    idle("R6", 9);
    step("R3", 1, 'h101, 1, 0, 0, 0, 0);
    idle("R6", 3);
    step("R3", 1, 'h0AA, 0, 0, 0, 0, 0);
    idle("R6", 2);

    // R4 interleaved
    step("R4", 1, 'h015, 3, 1, 0, 0, 0);
    idle("R4", 9);
    step("R4", 1, 'h01E, 2, 1, 0, 0, 0);
    idle("R4", 5);

    // R5 full page past the wrap, then R8 stop
    step("R5", 1, 'h1FC, 7, 0, 0, 0, 0);
    idle("R5", 520);
    step("R8", 0, 0, 0, 0, 0, 0, 1);
    idle("R8", 2);
    step("R8", 0, 0, 0, 0, 0, 0, 1);
    idle("R8", 2);

    // R7 refused settings while a burst runs
    step("R7", 1, 'h040, 3, 0, 0, 0, 0);
    idle("R7", 1);
    step("R7", 1, 'h123, 5, 0, 0, 0, 0);
    step("R7", 1, 'h077, 7, 1, 0, 0, 0);
    idle("R7", 7);
    step("R7", 1, 'h011, 6, 0, 0, 0, 0);
    step("R7", 1, 'h011, 4, 0, 0, 1, 0);
    idle("R7", 2);

    // R9 override and start-over-stop priority
    step("R9", 1, 'h080, 3, 0, 0, 0, 0);
    idle("R9", 2);
    step("R9", 1, 'h033, 2, 0, 0, 0, 0);
    idle("R9", 1);
    step("R9", 1, 'h0F1, 1, 1, 0, 0, 1);
    idle("R9", 4);

    // R10 single-write mode
    step("R10", 1, 'h0C5, 2, 0, 1, 0, 0);
    idle("R10", 5);
    step("R10", 1, 'h0C5, 3, 0, 1, 1, 0);
    idle("R10", 3);
    step("R10", 1, 'h0C5, 2, 1, 0, 1, 0);
    idle("R10", 5);
    step("R10", 1, 'h1F0, 7, 0, 1, 1, 0);
    idle("R10", 3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule